// File: doc/BRIEF.md
# Banked Flash Query Read Formatter

This block builds the read word that a bank of identical flash devices, wired side by side on one data bus, returns while it is in one of its non-array read modes. The bank width, the width each device is used at and the widest mode each device supports are parameters. The block is told the byte address of the read, the access size and which of three modes the bank is in: status, identifier or query. It returns the matching bus word one clock later.

In query mode the bus address is scaled down to the offset a single device uses at its native width. A byte is fetched from a parameterised query table, spread into one device's response and copied across every device lane of the bank. Identifier mode works the same way, with the manufacturer and device codes standing in for the table. Status mode copies an 8-bit status byte into each device lane. A read wider than the bank is put together from several bank-wide results taken at successive bank-width address steps. Parameter sets that would give a negative address shift, or an unsupported narrow-use configuration, are rejected at elaboration.

Top module: `banked_query_fmt`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high and low otherwise; `rd_data` holds the result in that cycle. Reset drives `rd_valid` and `rd_data` to zero.
- R2: The query and identifier offset is `rd_addr` shifted right by log2(BANK_BYTES) + log2(MAX_DEV_BYTES) − log2(DEV_BYTES); the address bits shifted out have no effect (2 for the default set).
- R3: The query table holds 0x51, 0x52, 0x59 at offsets 0x10 to 0x12, 0x01 at 0x13, 0x00 at 0x14, 0x31 at 0x15, 0x00 at 0x16, 0x50, 0x52, 0x49, 0x31, 0x30 at 0x31 to 0x35, 0x01 at 0x3F and 0x00 at 0x00 to 0x0F.
- R4: A query offset at or above TABLE_DEPTH (82 by default) returns zero, with no wrap of the high offset bits.
- R5: When DEV_BYTES equals MAX_DEV_BYTES, each device lane of DEV_BYTES bytes carries the table byte in its lowest byte and zero above it, and every device lane of the bank carries the same value.
- R6: When DEV_BYTES is below MAX_DEV_BYTES (byte use, DEV_BYTES 1), every byte of the bank carries the table byte.
- R7: Identifier mode returns MFR_CODE for offset low byte 0 and DEVICE_CODE for low byte 1, least significant byte in the lowest byte of each device lane, truncated to the device width; any other low byte (including 2 and 3) returns zero; offset bits above the low byte are ignored.
- R8: For a read wider than the bank, bytes k·BANK_BYTES upward carry the bank result for address `rd_addr` + k·BANK_BYTES.
- R9: Status mode puts `status_byte` into the lowest byte of every device lane (bytes at multiples of DEV_BYTES) and zero elsewhere.
- R10: `rd_size` is log2 of the access size in bytes; bytes at and above 2^`rd_size` are zero, and a code beyond the bus width selects the whole bus.
- R11: `rd_mode` encodes 0 status, 1 identifier, 2 query; code 3 returns an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte address of the read on the bank bus |
| rd_size | input | SIZE_W | log2 of the access size in bytes |
| rd_mode | input | 2 | Read mode: 0 status, 1 identifier, 2 query, 3 none |
| status_byte | input | 8 | Current status value of one device |
| rd_data | output | 8*DATA_BYTES | Formatted read word |
| rd_valid | output | 1 | High when `rd_data` holds a result |

## Verification
The assertions take for granted that `rd_mode`, `rd_size` and `status_byte` are stable with the strobe in the cycle `rd_en` is high, and that lane equality is only judged when the access size covers a full bank. The stimulus drives every input on the falling edge alongside the strobe, uses only the four mode codes and the two-bit size codes, and reads query offsets whose table contents the requirements fix. A second instance in byte-use configuration receives the same reads so that the repeated-byte lane rule is exercised with identical addresses.

// File: rtl/qfmt_pkg.sv
package qfmt_pkg;

   typedef enum logic [1:0] {
      QF_STATUS = 2'd0,
      QF_IDENT  = 2'd1,
      QF_QUERY  = 2'd2,
      QF_NONE   = 2'd3
   } qf_mode_e;

   // Query table contents, one byte per device-native offset.
   function automatic logic [7:0] qf_rom_byte(input logic [31:0] off,
                                              input int unsigned size_log2,
                                              input int unsigned buf_log2,
                                              input int unsigned blocks,
                                              input int unsigned sector_bytes);
      logic [31:0] bm1;
      logic [31:0] sec;
      bm1 = 32'(blocks) - 32'd1;
      sec = 32'(sector_bytes);
      case (off)
         32'h10: qf_rom_byte = 8'h51;
         32'h11: qf_rom_byte = 8'h52;
         32'h12: qf_rom_byte = 8'h59;
         32'h13: qf_rom_byte = 8'h01;
         32'h15: qf_rom_byte = 8'h31;
         32'h1B: qf_rom_byte = 8'h45;
         32'h1C: qf_rom_byte = 8'h55;
         32'h1F: qf_rom_byte = 8'h07;
         32'h20: qf_rom_byte = 8'h07;
         32'h21: qf_rom_byte = 8'h0A;
         32'h23: qf_rom_byte = 8'h04;
         32'h24: qf_rom_byte = 8'h04;
         32'h25: qf_rom_byte = 8'h04;
         32'h27: qf_rom_byte = 8'(size_log2);
         32'h28: qf_rom_byte = 8'h02;
         32'h2A: qf_rom_byte = 8'(buf_log2);
         32'h2C: qf_rom_byte = 8'h01;
         32'h2D: qf_rom_byte = bm1[7:0];
         32'h2E: qf_rom_byte = bm1[15:8];
         32'h2F: qf_rom_byte = sec[15:8];
         32'h30: qf_rom_byte = sec[23:16];
         32'h31: qf_rom_byte = 8'h50;
         32'h32: qf_rom_byte = 8'h52;
         32'h33: qf_rom_byte = 8'h49;
         32'h34: qf_rom_byte = 8'h31;
         32'h35: qf_rom_byte = 8'h30;
         32'h3F: qf_rom_byte = 8'h01;
         default: qf_rom_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/qfmt_lane_rep.sv
module qfmt_lane_rep #(
   parameter int LANE_BITS = 16,
   parameter int LANES     = 2
) (
   input  logic [LANE_BITS-1:0]       lane_in,
   output logic [LANE_BITS*LANES-1:0] word_out
);
   assign word_out = {LANES{lane_in}};
endmodule

// File: rtl/qfmt_status_spread.sv
module qfmt_status_spread #(
   parameter int DATA_BYTES = 8,
   parameter int DEV_BYTES  = 2
) (
   input  logic [7:0]              status_byte,
   output logic [8*DATA_BYTES-1:0] word_out
);
   for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
      if ((b % DEV_BYTES) == 0) begin : g_lead
         assign word_out[8*b +: 8] = status_byte;
      end else begin : g_pad
         assign word_out[8*b +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/qfmt_bank_lookup.sv
module qfmt_bank_lookup
   import qfmt_pkg::*;
#(
   parameter int          BANK_BYTES    = 4,
   parameter int          DEV_BYTES     = 2,
   parameter int          MAX_DEV_BYTES = 2,
   parameter int          ADDR_W        = 12,
   parameter int          TABLE_DEPTH   = 82,
   parameter int          IDENT_W       = 16,
   parameter logic [15:0] MFR_CODE      = 16'h1F2E,
   parameter logic [15:0] DEVICE_CODE   = 16'h7A5B,
   parameter int unsigned DEV_SIZE_LOG2 = 23,
   parameter int unsigned BUF_LOG2      = 11,
   parameter int unsigned BLOCKS        = 128,
   parameter int unsigned SECTOR_BYTES  = 65536
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel_query,
   output logic [8*BANK_BYTES-1:0] word
);
   localparam int SHIFT = $clog2(BANK_BYTES) + $clog2(MAX_DEV_BYTES) - $clog2(DEV_BYTES);
   localparam int DW    = 8 * DEV_BYTES;
   localparam int LANES = BANK_BYTES / DEV_BYTES;

   logic [ADDR_W-1:0]  off;
   logic [7:0]         tbl_byte;
   logic [IDENT_W-1:0] ident;
   logic [DW-1:0]      dev_q;
   logic [DW-1:0]      dev_word;

   assign off = addr >> SHIFT;

   always_comb begin
      if (32'(off) < 32'(TABLE_DEPTH))
         tbl_byte = qf_rom_byte(32'(off), DEV_SIZE_LOG2, BUF_LOG2, BLOCKS, SECTOR_BYTES);
      else
         tbl_byte = 8'h00;
   end

   always_comb begin
      case (off[7:0])
         8'd0:    ident = IDENT_W'(MFR_CODE);
         8'd1:    ident = IDENT_W'(DEVICE_CODE);
         default: ident = '0;
      endcase
   end

   // Device response to a query: repeated in narrow use, zero padded in native use
   if (DEV_BYTES < MAX_DEV_BYTES) begin : g_narrow
      logic [8*MAX_DEV_BYTES-1:0] rep;
      assign rep   = {MAX_DEV_BYTES{tbl_byte}};
      assign dev_q = rep[DW-1:0];
   end else begin : g_native
      assign dev_q = DW'(tbl_byte);
   end

   assign dev_word = sel_query ? dev_q : DW'(ident);

   qfmt_lane_rep #(.LANE_BITS(DW), .LANES(LANES)) u_rep (
      .lane_in  (dev_word),
      .word_out (word)
   );
endmodule

// File: rtl/banked_query_fmt.sv
module banked_query_fmt
   import qfmt_pkg::*;
#(
   parameter int          DATA_BYTES    = 8,
   parameter int          BANK_BYTES    = 4,
   parameter int          DEV_BYTES     = 2,
   parameter int          MAX_DEV_BYTES = 2,
   parameter int          ADDR_W        = 12,
   parameter int          TABLE_DEPTH   = 82,
   parameter int          IDENT_W       = 16,
   parameter logic [15:0] MFR_CODE      = 16'h1F2E,
   parameter logic [15:0] DEVICE_CODE   = 16'h7A5B,
   parameter int unsigned DEV_SIZE_LOG2 = 23,
   parameter int unsigned BUF_LOG2      = 11,
   parameter int unsigned BLOCKS        = 128,
   parameter int unsigned SECTOR_BYTES  = 65536,
   localparam int         SIZE_W        = ($clog2($clog2(DATA_BYTES) + 1) < 1) ? 1
                                          : $clog2($clog2(DATA_BYTES) + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [SIZE_W-1:0]       rd_size,
   input  logic [1:0]              rd_mode,
   input  logic [7:0]              status_byte,
   output logic [8*DATA_BYTES-1:0] rd_data,
   output logic                    rd_valid
);
   localparam int DBITS    = 8 * DATA_BYTES;
   localparam int BBITS    = 8 * BANK_BYTES;
   localparam int CHUNKS   = DATA_BYTES / BANK_BYTES;
   localparam int LOG_DATA = $clog2(DATA_BYTES);

   // Elaboration checks on the parameter set
   if (DEV_BYTES > MAX_DEV_BYTES) begin : g_err_shift
      $error("device width above maximum device width gives a negative shift");
   end
   if (DEV_BYTES < MAX_DEV_BYTES && (DEV_BYTES != 1 || BANK_BYTES > 4)) begin : g_err_narrow
      $error("narrow use needs device width 1 and bank width at most 4");
   end
   if ((BANK_BYTES % DEV_BYTES) != 0 || (DATA_BYTES % BANK_BYTES) != 0) begin : g_err_div
      $error("bank must hold whole devices and bus must hold whole banks");
   end
   if ((DATA_BYTES & (DATA_BYTES - 1)) != 0 || (BANK_BYTES & (BANK_BYTES - 1)) != 0 ||
       (DEV_BYTES & (DEV_BYTES - 1)) != 0 || (MAX_DEV_BYTES & (MAX_DEV_BYTES - 1)) != 0) begin : g_err_pow2
      $error("all widths must be powers of two");
   end

   logic                sel_query;
   logic [DBITS-1:0]    chunk_word;
   logic [DBITS-1:0]    status_word;
   logic [DBITS-1:0]    fmt_word;
   logic [DBITS-1:0]    byte_mask;
   logic [SIZE_W-1:0]   size_eff;

   assign sel_query = (rd_mode == QF_QUERY);

   for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
      qfmt_bank_lookup #(
         .BANK_BYTES    (BANK_BYTES),
         .DEV_BYTES     (DEV_BYTES),
         .MAX_DEV_BYTES (MAX_DEV_BYTES),
         .ADDR_W        (ADDR_W),
         .TABLE_DEPTH   (TABLE_DEPTH),
         .IDENT_W       (IDENT_W),
         .MFR_CODE      (MFR_CODE),
         .DEVICE_CODE   (DEVICE_CODE),
         .DEV_SIZE_LOG2 (DEV_SIZE_LOG2),
         .BUF_LOG2      (BUF_LOG2),
         .BLOCKS        (BLOCKS),
         .SECTOR_BYTES  (SECTOR_BYTES)
      ) u_lookup (
         .addr      (rd_addr + ADDR_W'(k * BANK_BYTES)),
         .sel_query (sel_query),
         .word      (chunk_word[k*BBITS +: BBITS])
      );
   end

   qfmt_status_spread #(.DATA_BYTES(DATA_BYTES), .DEV_BYTES(DEV_BYTES)) u_status (
      .status_byte (status_byte),
      .word_out    (status_word)
   );

   always_comb begin
      case (rd_mode)
         QF_STATUS:          fmt_word = status_word;
         QF_IDENT, QF_QUERY: fmt_word = chunk_word;
         default:            fmt_word = '0;
      endcase
   end

   always_comb begin
      size_eff = (32'(rd_size) > 32'(LOG_DATA)) ? SIZE_W'(LOG_DATA) : rd_size;
      for (int b = 0; b < DATA_BYTES; b++)
         byte_mask[8*b +: 8] = (b < (1 << size_eff)) ? 8'hFF : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en)
            rd_data <= fmt_word & byte_mask;
      end
   end
endmodule

// File: rtl/banked_query_fmt_chk.sv
module banked_query_fmt_chk
   import qfmt_pkg::*;
#(
   parameter int DATA_BYTES = 8,
   parameter int BANK_BYTES = 4,
   parameter int DEV_BYTES  = 2,
   parameter int SIZE_W     = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    rd_en,
   input logic [SIZE_W-1:0]       rd_size,
   input logic [1:0]              rd_mode,
   input logic [7:0]              status_byte,
   input logic [8*DATA_BYTES-1:0] rd_data,
   input logic                    rd_valid
);
   localparam int DBITS    = 8 * DATA_BYTES;
   localparam int DW       = 8 * DEV_BYTES;
   localparam int LANES    = BANK_BYTES / DEV_BYTES;
   localparam int LOG_BANK = $clog2(BANK_BYTES);

   logic [SIZE_W-1:0] size_q;
   logic [LANES-1:0]  lane_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) size_q <= '0;
      else if (rd_en) size_q <= rd_size;
   end

   function automatic logic [DBITS-1:0] kept(input logic [SIZE_W-1:0] s);
      for (int b = 0; b < DATA_BYTES; b++)
         kept[8*b +: 8] = (b < (32'd1 << s)) ? 8'hFF : 8'h00;
   endfunction

   assign lane_ok[0] = 1'b1;
   for (genvar l = 1; l < LANES; l++) begin : g_lane
      assign lane_ok[l] = (rd_data[l*DW +: DW] == rd_data[DW-1:0]);
   end

   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);  // R1
   AST_NO_VALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);  // R1
   AST_STATUS_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_mode == QF_STATUS) |=> (rd_data[7:0] == $past(status_byte)));  // R9
   AST_NONE_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_mode == QF_NONE) |=> (rd_data == '0));  // R11
   AST_BEYOND_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ((rd_data & ~kept(size_q)) == '0));  // R10
   AST_DEVICE_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_mode == QF_IDENT || rd_mode == QF_QUERY) && (32'(rd_size) >= 32'(LOG_BANK)))
      |=> (&lane_ok));  // R5
endmodule

bind banked_query_fmt banked_query_fmt_chk #(
   .DATA_BYTES (DATA_BYTES),
   .BANK_BYTES (BANK_BYTES),
   .DEV_BYTES  (DEV_BYTES),
   .SIZE_W     (SIZE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .rd_size     (rd_size),
   .rd_mode     (rd_mode),
   .status_byte (status_byte),
   .rd_data     (rd_data),
   .rd_valid    (rd_valid)
);

// File: tb/sim_banked_query_fmt.sv
`timescale 1ns/1ps
module sim_banked_query_fmt;
   localparam logic [15:0] MFR = 16'h1F2E;
   localparam logic [15:0] DID = 16'h7A5B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [1:0]  rd_size = '0;
   logic [1:0]  rd_mode = '0;
   logic [7:0]  status_byte = '0;
   logic [63:0] data0;
   logic [31:0] data1;
   logic        valid0, valid1;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   // Native-width bank: 4-byte bank of 2-byte devices on an 8-byte bus
   banked_query_fmt #(.DATA_BYTES(8), .BANK_BYTES(4), .DEV_BYTES(2), .MAX_DEV_BYTES(2),
                      .MFR_CODE(MFR), .DEVICE_CODE(DID)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
      .rd_mode(rd_mode), .status_byte(status_byte), .rd_data(data0), .rd_valid(valid0));

   // Byte-use bank: 2-byte bank of 2-byte-capable devices used 1 byte wide, 4-byte bus
   banked_query_fmt #(.DATA_BYTES(4), .BANK_BYTES(2), .DEV_BYTES(1), .MAX_DEV_BYTES(2),
                      .MFR_CODE(MFR), .DEVICE_CODE(DID)) u1 (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size),
      .rd_mode(rd_mode), .status_byte(status_byte), .rd_data(data1), .rd_valid(valid1));

   typedef struct {
      logic [63:0] e0;
      logic [31:0] e1;
      string       tag;
   } exp_t;
   exp_t sb[$];

   function automatic logic [7:0] tbl(input int off);
      case (off)
         'h10: tbl = 8'h51;  'h11: tbl = 8'h52;  'h12: tbl = 8'h59;
         'h13: tbl = 8'h01;  'h15: tbl = 8'h31;
         'h31: tbl = 8'h50;  'h32: tbl = 8'h52;  'h33: tbl = 8'h49;
         'h34: tbl = 8'h31;  'h35: tbl = 8'h30;  'h3F: tbl = 8'h01;
         default: tbl = 8'h00;
      endcase
   endfunction

   function automatic logic [63:0] model(input int bank, input int dev, input int maxd,
                                         input int dbytes, input int mode, input int addr,
                                         input int size, input logic [7:0] st);
      int sh, acc;
      logic [63:0] r;
      sh  = $clog2(bank) + $clog2(maxd) - $clog2(dev);
      acc = 1 << size;
      if (acc > dbytes) acc = dbytes;
      r = '0;
      for (int b = 0; b < acc; b++) begin
         int k, j, a, off;
         logic [15:0] code;
         k   = b / bank;
         j   = (b % bank) % dev;
         a   = (addr + k * bank) & 'hFFF;
         off = a >> sh;
         case (mode)
            0: r[8*b +: 8] = (j == 0) ? st : 8'h00;
            1: begin
               code = ((off & 'hFF) == 0) ? MFR : ((off & 'hFF) == 1) ? DID : 16'h0;
               r[8*b +: 8] = (j < 2) ? code[8*j +: 8] : 8'h00;
            end
            2: r[8*b +: 8] = (j == 0 && off < 82) ? tbl(off) : 8'h00;
            default: r[8*b +: 8] = 8'h00;
         endcase
      end
      model = r;
   endfunction

   task automatic check(input bit ok, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // Driver: present one read for a cycle and queue what both instances must return
   task automatic do_read(input int mode, input int addr, input int size,
                          input logic [7:0] st, input string tag);
      exp_t it;
      @(negedge clk);
      rd_en       = 1'b1;
      rd_mode     = 2'(mode);
      rd_addr     = 12'(addr);
      rd_size     = 2'(size);
      status_byte = st;
      it.e0  = model(4, 2, 2, 8, mode, addr, size, st);
      it.e1  = 32'(model(2, 1, 2, 4, mode, addr, size, st));
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // Monitor: compare each result against the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && (valid0 || valid1)) begin
         if (sb.size() == 0) begin
            check(1'b0, "R1 valid without a read", {63'd0, valid0}, 64'd0);
         end else begin
            exp_t it;
            it = sb.pop_front();
            check(valid0 && valid1, {"R1 both valid ", it.tag}, {62'd0, valid1, valid0}, 64'd3);
            check(data0 == it.e0, {"u0 ", it.tag}, data0, it.e0);
            check(data1 == it.e1, {"u1 R6 ", it.tag}, {32'd0, data1}, {32'd0, it.e1});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(valid0 == 1'b0 && data0 == '0, "R1 reset state u0", data0, 64'd0);
      check(valid1 == 1'b0 && data1 == '0, "R1 reset state u1", {32'd0, data1}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid0 == 1'b0, "R1 idle after reset", {63'd0, valid0}, 64'd0);

      // Query table and offset scaling
      for (int s = 0; s < 4; s++) do_read(2, 'h40, s, 8'h00, "R3 R5 R8 R10 query Q sizes");
      do_read(2, 'h41, 2, 8'h00, "R2 low address bits ignored");
      do_read(2, 'h44, 2, 8'h00, "R3 query R");
      do_read(2, 'h48, 2, 8'h00, "R3 query Y");
      do_read(2, 'h4C, 3, 8'h00, "R3 R8 command set");
      do_read(2, 'h54, 3, 8'h00, "R3 R8 extended table address");
      for (int o = 'h31; o <= 'h35; o++) do_read(2, o * 4, 2, 8'h00, "R3 extended letters");
      do_read(2, 'hFC, 3, 8'h00, "R3 R8 protection count");
      do_read(2, 'h20, 3, 8'h00, "R3 low offsets zero");
      do_read(2, 'h148, 3, 8'h00, "R4 first offset past table");
      do_read(2, 'h440, 3, 8'h00, "R4 high offset no wrap");

      // Identifier mode
      do_read(1, 'h000, 3, 8'h00, "R7 R8 manufacturer and device");
      do_read(1, 'h004, 2, 8'h00, "R7 device code");
      do_read(1, 'h008, 3, 8'h00, "R7 lock offsets zero");
      do_read(1, 'h400, 3, 8'h00, "R7 upper offset bits ignored");
      do_read(1, 'h004, 0, 8'h00, "R7 R10 narrow identifier");

      // Status mode
      for (int s = 0; s < 4; s++) do_read(0, 'h000, s, 8'h80, "R9 R10 status sizes");
      do_read(0, 'h123, 3, 8'hA5, "R9 status pattern");

      // Unused mode code
      do_read(3, 'h040, 3, 8'hFF, "R11 mode 3 zero");

      // Back-to-back reads followed by idle
      do_read(2, 'h40, 1, 8'h00, "R1 back to back a");
      do_read(1, 'h04, 1, 8'h00, "R1 back to back b");
      @(negedge clk);
      @(negedge clk);
      check(valid0 == 1'b0 && valid1 == 1'b0, "R1 valid drops when idle",
            {62'd0, valid1, valid0}, 64'd0);
      check(sb.size() == 0, "R1 every read answered", 64'(sb.size()), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule